// File: doc/BRIEF.md
# Companion-Chip GPIO and Control Register Block

This block is the register front end of a handheld companion chip. A host reaches it through a simple synchronous register bus. The bus has an address, a write strobe with write data, and a read strobe with registered read data. The block holds six plain 16-bit control words and a power word with a bit side effect. It also has a constant status word and a 16-line general-purpose I/O unit.

Each I/O line has a direction bit (1 = output) and a level bit. The block drives the level masked by direction onto its outputs. That driven vector is refreshed only when the host writes the direction word or a level alias. In the cycle a line's driven value changes, that line raises a one-cycle change pulse.

External inputs can load individual level bits at any time. Such a load is visible on readback, but it does not refresh the driven vector until the next direction or level write. The block decodes a 4 KB window, and all unused offsets are inert.

Top module: `cgpio_regblk`

## Requirements
- R1: After reset, every readable word is 0 except the status word at offset 0x08, which reads 0x0002. `gpio_out`, `gpio_chg` and `bus_rdata` are all 0.
- R2: A write keeps only the low 16 bits of `bus_wdata`. The plain words at offsets 0x00, 0x04, 0x10, 0x14, 0x18 and 0x1C read back exactly those 16 bits, with bits 31:16 of `bus_rdata` zero.
- R3: A write to the power word at offset 0x0C with bit 7 set stores the value OR 0x8040. With bit 7 clear, it stores the value unchanged.
- R4: The status word at offset 0x08 always reads 0x0002, and writes to it have no effect.
- R5: A write to offset 0x20 sets the direction bits (1 = output). In the next cycle `gpio_out` equals the current level AND the new direction, and the level word itself is not altered.
- R6: A write to offset 0x24 or 0x28 stores (write data AND current direction) into the level word. A read of either offset returns the level word.
- R7: `gpio_out` changes only in the cycle after a write to 0x20, 0x24 or 0x28. In that cycle, `gpio_chg` has a 1 for exactly the lines whose driven value changed, and in every other cycle `gpio_chg` is 0.
- R8: In a cycle with `ext_en[i]` high, bit i of the level word takes `ext_val[i]`; other bits are untouched. This alone does not change `gpio_out` and raises no change pulse.
- R9: If a level write (0x24 or 0x28) and external loads occur in the same cycle, the bus write decides the whole level word.
- R10: Reads of unmapped offsets (not a multiple of 4, or above 0x28 inside the 4 KB window) return 0, and writes to them change nothing.
- R11: `bus_rdata` presents the addressed word one cycle after `bus_re`. It shows the value from before any write in the same cycle, and it is 0 in a cycle after one with `bus_re` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W (12) | Byte offset inside the window |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | DATA_W (32) | Registered read data |
| ext_en | input | 16 | Per-line external load enable |
| ext_val | input | 16 | Per-line external level value |
| gpio_out | output | 16 | Driven line values (level AND direction) |
| gpio_chg | output | 16 | One-cycle per-line change pulse |

## Verification
- **Read data:** it is due one edge after the edge that samples `bus_re`. The bench raises the strobe at a falling edge and reads `bus_rdata` at the following falling edge.
- **Driven vector and change pulse:** both are registered on the same edge that takes the direction or level write. They are checked at the falling edge straight after that write. The pulse is checked again one cycle later, when it must be gone.
- **External loads:** these have no direct output, so their effect is checked through a level readback. The bench also confirms that `gpio_out` stayed put and that no pulse appeared.

// File: rtl/cgpio_pkg.sv
package cgpio_pkg;

    localparam int REG_W = 16;

    typedef logic [REG_W-1:0] reg_t;

    localparam int   PWR_TRIG_BIT   = 7;
    localparam reg_t PWR_FORCE_MASK = 16'h8040;
    localparam reg_t STATUS_VALUE   = 16'h0002;

    typedef enum logic [3:0] {
        SEL_CFG0,
        SEL_CFG1,
        SEL_STAT,
        SEL_PWR,
        SEL_CFG2,
        SEL_IRQRAW,
        SEL_IRQMSK,
        SEL_IRQSTS,
        SEL_DIR,
        SEL_LVL,
        SEL_LVL_ALT,
        SEL_NONE
    } reg_sel_e;

    typedef struct packed {
        reg_t cfg0;
        reg_t cfg1;
        reg_t pwr;
        reg_t cfg2;
        reg_t irq_raw;
        reg_t irq_msk;
        reg_t irq_sts;
        reg_t dir;
        reg_t lvl;
        reg_t drv;
        reg_t chg;
    } blk_state_t;

endpackage

// File: rtl/cgpio_addr_dec.sv
module cgpio_addr_dec
    import cgpio_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);
    localparam int IW = ADDR_W - 2;

    always_comb begin
        sel = SEL_NONE;
        if (addr[1:0] == 2'b00) begin
            case (addr[ADDR_W-1:2])
                IW'(0):  sel = SEL_CFG0;
                IW'(1):  sel = SEL_CFG1;
                IW'(2):  sel = SEL_STAT;
                IW'(3):  sel = SEL_PWR;
                IW'(4):  sel = SEL_CFG2;
                IW'(5):  sel = SEL_IRQRAW;
                IW'(6):  sel = SEL_IRQMSK;
                IW'(7):  sel = SEL_IRQSTS;
                IW'(8):  sel = SEL_DIR;
                IW'(9):  sel = SEL_LVL;
                IW'(10): sel = SEL_LVL_ALT;
                default: sel = SEL_NONE;
            endcase
        end
    end
endmodule

// File: rtl/cgpio_line_eval.sv
module cgpio_line_eval
    import cgpio_pkg::*;
(
    input  reg_t dir_q,
    input  reg_t lvl_q,
    input  reg_t drv_q,
    input  logic wr_dir,
    input  logic wr_lvl,
    input  reg_t wdata,
    input  reg_t ext_en,
    input  reg_t ext_val,
    output reg_t dir_d,
    output reg_t lvl_d,
    output reg_t drv_d,
    output reg_t chg_d
);
    reg_t lvl_ext;

    for (genvar i = 0; i < REG_W; i++) begin : g_line
        assign lvl_ext[i] = ext_en[i] ? ext_val[i] : lvl_q[i];
    end

    always_comb begin
        dir_d = dir_q;
        lvl_d = lvl_ext;
        if (wr_dir) begin
            dir_d = wdata;
        end
        if (wr_lvl) begin
            lvl_d = wdata & dir_q;
        end
        drv_d = (wr_dir || wr_lvl) ? (lvl_d & dir_d) : drv_q;
        chg_d = drv_d ^ drv_q;
    end
endmodule

// File: rtl/cgpio_regblk.sv
module cgpio_regblk
    import cgpio_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_re,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [15:0]       ext_en,
    input  logic [15:0]       ext_val,
    output logic [15:0]       gpio_out,
    output logic [15:0]       gpio_chg
);
    localparam int PAD_W = DATA_W - REG_W;

    blk_state_t        st_d, st_q;
    logic [DATA_W-1:0] rdata_d, rdata_q;
    reg_sel_e          sel;
    reg_t              wd;
    reg_t              rd_word;
    logic              wr_dir, wr_lvl;
    reg_t              ln_dir_d, ln_lvl_d, ln_drv_d, ln_chg_d;

    assign wd = bus_wdata[REG_W-1:0];

    cgpio_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .sel  (sel)
    );

    assign wr_dir = bus_we && (sel == SEL_DIR);
    assign wr_lvl = bus_we && ((sel == SEL_LVL) || (sel == SEL_LVL_ALT));

    cgpio_line_eval u_lines (
        .dir_q   (st_q.dir),
        .lvl_q   (st_q.lvl),
        .drv_q   (st_q.drv),
        .wr_dir  (wr_dir),
        .wr_lvl  (wr_lvl),
        .wdata   (wd),
        .ext_en  (ext_en),
        .ext_val (ext_val),
        .dir_d   (ln_dir_d),
        .lvl_d   (ln_lvl_d),
        .drv_d   (ln_drv_d),
        .chg_d   (ln_chg_d)
    );

    always_comb begin
        case (sel)
            SEL_CFG0:    rd_word = st_q.cfg0;
            SEL_CFG1:    rd_word = st_q.cfg1;
            SEL_STAT:    rd_word = STATUS_VALUE;
            SEL_PWR:     rd_word = st_q.pwr;
            SEL_CFG2:    rd_word = st_q.cfg2;
            SEL_IRQRAW:  rd_word = st_q.irq_raw;
            SEL_IRQMSK:  rd_word = st_q.irq_msk;
            SEL_IRQSTS:  rd_word = st_q.irq_sts;
            SEL_DIR:     rd_word = st_q.dir;
            SEL_LVL,
            SEL_LVL_ALT: rd_word = st_q.lvl;
            default:     rd_word = '0;
        endcase
    end

    always_comb begin
        st_d     = st_q;
        st_d.dir = ln_dir_d;
        st_d.lvl = ln_lvl_d;
        st_d.drv = ln_drv_d;
        st_d.chg = ln_chg_d;
        if (bus_we) begin
            case (sel)
                SEL_CFG0:   st_d.cfg0    = wd;
                SEL_CFG1:   st_d.cfg1    = wd;
                SEL_PWR:    st_d.pwr     = wd[PWR_TRIG_BIT] ? (wd | PWR_FORCE_MASK) : wd;
                SEL_CFG2:   st_d.cfg2    = wd;
                SEL_IRQRAW: st_d.irq_raw = wd;
                SEL_IRQMSK: st_d.irq_msk = wd;
                SEL_IRQSTS: st_d.irq_sts = wd;
                default:    ;
            endcase
        end
        rdata_d = bus_re ? {{PAD_W{1'b0}}, rd_word} : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= '0;
            rdata_q <= '0;
        end else begin
            st_q    <= st_d;
            rdata_q <= rdata_d;
        end
    end

    assign bus_rdata = rdata_q;
    assign gpio_out  = st_q.drv;
    assign gpio_chg  = st_q.chg;
endmodule

// File: rtl/cgpio_regblk_chk.sv
module cgpio_regblk_chk #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic              bus_re,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [15:0]       gpio_out,
    input logic [15:0]       gpio_chg
);
    logic gpio_wr;
    logic unmapped;

    assign gpio_wr = bus_we && ((bus_addr == ADDR_W'(32)) || (bus_addr == ADDR_W'(36))
                                || (bus_addr == ADDR_W'(40)));
    assign unmapped = (bus_addr[1:0] != 2'b00) || (bus_addr > ADDR_W'(40));

    AST_CHG_IS_DELTA: assert property (@(posedge clk) disable iff (rst)
        1'b1 |-> gpio_chg == (gpio_out ^ $past(gpio_out))); // R7

    AST_OUT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !$past(gpio_wr) |-> $stable(gpio_out)); // R8

    AST_READ_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !$past(bus_re) |-> bus_rdata == '0); // R11

    AST_STATUS_FIXED: assert property (@(posedge clk) disable iff (rst)
        ($past(bus_re) && $past(bus_addr) == ADDR_W'(8)) |-> bus_rdata == DATA_W'(2)); // R4

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
        ($past(bus_re) && $past(unmapped)) |-> bus_rdata == '0); // R10

    AST_PWR_FORCED: assert property (@(posedge clk) disable iff (rst)
        ($past(bus_re) && $past(bus_addr) == ADDR_W'(12) && bus_rdata[7])
        |-> (bus_rdata[15] && bus_rdata[6])); // R3
endmodule

bind cgpio_regblk cgpio_regblk_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_re    (bus_re),
    .bus_rdata (bus_rdata),
    .gpio_out  (gpio_out),
    .gpio_chg  (gpio_chg)
);

// File: tb/cgpio_regblk_test.sv
module cgpio_regblk_test;
    logic        clk = 1'b0;
    logic        rst;
    logic [11:0] bus_addr;
    logic        bus_we;
    logic [31:0] bus_wdata;
    logic        bus_re;
    logic [31:0] bus_rdata;
    logic [15:0] ext_en;
    logic [15:0] ext_val;
    logic [15:0] gpio_out;
    logic [15:0] gpio_chg;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    cgpio_regblk uut (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_re    (bus_re),
        .bus_rdata (bus_rdata),
        .ext_en    (ext_en),
        .ext_val   (ext_val),
        .gpio_out  (gpio_out),
        .gpio_chg  (gpio_chg)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_re = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_re = 1'b0;
        d = bus_rdata;
    endtask

    task automatic expect_read(input string req, input logic [11:0] a,
                               input logic [31:0] exp);
        logic [31:0] v;
        bus_read(a, v);
        check(req, $sformatf("read 0x%03h", a), v, exp);
    endtask

    task automatic t_reset();
        check("R1", "gpio_out", {16'h0, gpio_out}, 32'h0);
        check("R1", "gpio_chg", {16'h0, gpio_chg}, 32'h0);
        check("R1", "rdata", bus_rdata, 32'h0);
        for (int i = 0; i <= 10; i++) begin
            expect_read("R1", 12'(i * 4), (i == 2) ? 32'h2 : 32'h0);
        end
    endtask

    task automatic t_plain();
        bus_write(12'h000, 32'hABCD_1234);
        bus_write(12'h004, 32'h0000_BEEF);
        bus_write(12'h010, 32'hFFFF_0F0F);
        bus_write(12'h014, 32'h1234_8001);
        bus_write(12'h018, 32'h0000_FFFF);
        bus_write(12'h01C, 32'h5555_AAAA);
        expect_read("R2", 12'h000, 32'h1234);
        expect_read("R2", 12'h004, 32'hBEEF);
        expect_read("R2", 12'h010, 32'h0F0F);
        expect_read("R2", 12'h014, 32'h8001);
        expect_read("R2", 12'h018, 32'hFFFF);
        expect_read("R2", 12'h01C, 32'hAAAA);
    endtask

    task automatic t_power();
        bus_write(12'h00C, 32'h0000_0080);
        expect_read("R3", 12'h00C, 32'h80C0);
        bus_write(12'h00C, 32'h0000_0041);
        expect_read("R3", 12'h00C, 32'h0041);
        bus_write(12'h00C, 32'h1234_5680);
        expect_read("R3", 12'h00C, 32'hD6C0);
    endtask

    task automatic t_status();
        bus_write(12'h008, 32'h0000_FFFF);
        expect_read("R4", 12'h008, 32'h0002);
    endtask

    task automatic t_gpio();
        bus_write(12'h020, 32'h0000_00FF);
        check("R5", "out after dir, level 0", {16'h0, gpio_out}, 32'h0);
        bus_write(12'h024, 32'h0000_FFFF);
        check("R6", "out after level write", {16'h0, gpio_out}, 32'h00FF);
        check("R7", "chg after level write", {16'h0, gpio_chg}, 32'h00FF);
        @(negedge clk);
        check("R7", "chg one cycle later", {16'h0, gpio_chg}, 32'h0);
        check("R7", "out holds", {16'h0, gpio_out}, 32'h00FF);
        expect_read("R6", 12'h028, 32'h00FF);
        expect_read("R6", 12'h024, 32'h00FF);
        bus_write(12'h020, 32'h0000_0F0F);
        check("R5", "out after dir change", {16'h0, gpio_out}, 32'h000F);
        check("R7", "chg after dir change", {16'h0, gpio_chg}, 32'h00F0);
        expect_read("R5", 12'h024, 32'h00FF);
        expect_read("R5", 12'h020, 32'h0F0F);
    endtask

    task automatic ext_pulse(input logic [15:0] en, input logic [15:0] val);
        @(negedge clk);
        ext_en = en; ext_val = val;
        @(posedge clk);
        @(negedge clk);
        ext_en = 16'h0;
    endtask

    task automatic t_ext();
        ext_pulse(16'h0100, 16'h0100);
        check("R8", "out unchanged by ext", {16'h0, gpio_out}, 32'h000F);
        check("R8", "no chg from ext", {16'h0, gpio_chg}, 32'h0);
        expect_read("R8", 12'h024, 32'h01FF);
        bus_write(12'h020, 32'h0000_0F0F);
        check("R7", "out after re-eval", {16'h0, gpio_out}, 32'h010F);
        check("R7", "chg after re-eval", {16'h0, gpio_chg}, 32'h0100);
        ext_pulse(16'h0001, 16'h0000);
        expect_read("R8", 12'h028, 32'h01FE);
        check("R8", "out unchanged by ext clear", {16'h0, gpio_out}, 32'h010F);
    endtask

    task automatic t_priority();
        @(negedge clk);
        bus_addr = 12'h028; bus_wdata = 32'h0; bus_we = 1'b1;
        ext_en = 16'hFFFF; ext_val = 16'hFFFF;
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0; ext_en = 16'h0;
        check("R9", "out after contested write", {16'h0, gpio_out}, 32'h0);
        check("R9", "chg after contested write", {16'h0, gpio_chg}, 32'h010F);
        expect_read("R9", 12'h024, 32'h0000);
    endtask

    task automatic t_unmapped();
        bus_write(12'h02C, 32'hFFFF_FFFF);
        bus_write(12'h001, 32'hFFFF_FFFF);
        bus_write(12'h022, 32'hFFFF_FFFF);
        bus_write(12'hFFC, 32'hFFFF_FFFF);
        expect_read("R10", 12'h02C, 32'h0);
        expect_read("R10", 12'h001, 32'h0);
        expect_read("R10", 12'h800, 32'h0);
        expect_read("R10", 12'h000, 32'h1234);
        expect_read("R10", 12'h020, 32'h0F0F);
        check("R10", "out unaffected", {16'h0, gpio_out}, 32'h0);
    endtask

    task automatic t_latency();
        @(negedge clk);
        bus_addr = 12'h004; bus_wdata = 32'h5555; bus_we = 1'b1; bus_re = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0; bus_re = 1'b0;
        check("R11", "read during write gives old", bus_rdata, 32'hBEEF);
        @(negedge clk);
        check("R11", "idle rdata is zero", bus_rdata, 32'h0);
        expect_read("R11", 12'h004, 32'h5555);
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        summary();
    end

    initial begin
        rst = 1'b1;
        bus_addr = '0; bus_we = 1'b0; bus_wdata = '0; bus_re = 1'b0;
        ext_en = '0; ext_val = '0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_plain();
        t_power();
        t_status();
        t_gpio();
        t_ext();
        t_priority();
        t_unmapped();
        t_latency();
        repeat (2) @(negedge clk);
        summary();
    end
endmodule